// File: doc/BRIEF.md
# SDI Serial Receive Deframer

This block takes a recovered serial video bit stream, one bit per clock of its bit-rate clock, and returns aligned 10-bit parallel words. The stream first passes through an NRZI decoder and then through a self-synchronizing descrambler. The descrambled bits go into a three-word window. In that window a timing reference preamble (one all-ones word followed by two all-zeros words) fixes where each word begins. A single-cycle word enable pulses once every ten bit clocks, giving the divide-by-ten word rate.

A lock state machine watches the preamble. It has three states: `ST_SEEK` (no alignment), `ST_VERIFY` (a preamble has been seen once) and `ST_LOCKED`. The transitions are:

- **seek-to-verify:** any preamble moves `ST_SEEK` to `ST_VERIFY`.
- **confirm:** a preamble at the current word boundary moves `ST_VERIFY` to `ST_LOCKED`.
- **slip:** a preamble at any other bit offset moves `ST_VERIFY` or `ST_LOCKED` to `ST_VERIFY`, and the boundary realigns.
- **timeout:** a run of words with no preamble moves `ST_VERIFY` or `ST_LOCKED` to `ST_SEEK`.

The run length for the timeout is set by `MISS_WORDS`. The `locked` output is high only in `ST_LOCKED`. A bypass input turns off both NRZI decoding and descrambling together, for streams that are already in plain binary.

Top module: `sdi_rx_deframer`

## Requirements
- R1: With `bypass` low, the decoded bit is the current `ser_in` XOR the previous `ser_in`; the previous value is 0 after reset.
- R2: With `bypass` low, the decoded bits are descrambled by x^9+x^4+1. Each recovered bit is the decoded bit XOR the decoded bits 4 and 9 clocks earlier.
- R3: With `bypass` high, `ser_in` goes straight into word assembly, with no NRZI decoding and no descrambling.
- R4: Bits are assembled least significant bit first: the first bit of a word in time becomes `word_out[0]`.
- R5: `word_en` is high for one cycle per word. While `locked` stays high, successive pulses are exactly 10 clocks apart, and `word_out` holds the new word in the pulse cycle.
- R6: The preamble is 3FF, 000, 000 in time order. The bit after its last bit is bit 0 of the next word, so that word and the ones following it are output unchanged.
- R7: `locked` rises only after a second preamble arrives at the same boundary as the first (`ST_SEEK` then `ST_VERIFY` then `ST_LOCKED`). It rises the cycle after that preamble is recognised.
- R8: A preamble at a different bit offset moves the boundary to it and drops `locked` (state `ST_VERIFY`). A following preamble at that offset restores `locked`, and the words are then correct.
- R9: After `MISS_WORDS` emitted words with no preamble, the state returns to `ST_SEEK` and `locked` goes low.
- R10: During and right after reset, `locked` and `word_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial line bit, sampled every clock |
| bypass | input | 1 | High: no NRZI decode and no descrambling |
| word_out | output | 10 | Aligned parallel word, LSB received first |
| word_en | output | 1 | One-cycle pulse marking a new word |
| locked | output | 1 | High while in `ST_LOCKED` |

## Verification
The hardest case to reach from the ports is a preamble arriving at a new bit offset while the block is locked. This has to happen without the descrambler losing sync. The bench does this by pushing three extra payload bits through its own scrambler and NRZI encoder model, so the line stream stays self-consistent while every later word boundary shifts by three bits. The next preamble must then drop `locked`, and the following one must restore it with correct payload. Payload values are chosen so that no run of twenty zeros can occur, so a false preamble is impossible.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;

    typedef enum logic [1:0] {
        ST_SEEK   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;

endpackage

// File: rtl/sdi_rx_bitdec.sv
// Line-code front end: NRZI decode, then self-synchronizing descramble.
module sdi_rx_bitdec #(
    parameter int TAP_A = 4,
    parameter int TAP_B = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_bit,
    input  logic bypass,
    output logic data_bit
);
    localparam int HIST_W = TAP_B;

    logic              prev_line;
    logic [HIST_W-1:0] hist;
    logic              nrz_bit;
    logic              desc_bit;

    assign nrz_bit  = line_bit ^ prev_line;
    assign desc_bit = nrz_bit ^ hist[TAP_A-1] ^ hist[TAP_B-1];
    assign data_bit = bypass ? line_bit : desc_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_line <= 1'b0;
            hist      <= '0;
        end else begin
            prev_line <= line_bit;
            hist      <= {hist[HIST_W-2:0], nrz_bit};
        end
    end
endmodule

// File: rtl/sdi_rx_sync_det.sv
// Recognises one all-ones word followed by two all-zeros words in the window.
module sdi_rx_sync_det #(
    parameter int WORD_W = 10
) (
    input  logic [3*WORD_W-1:0] window,
    output logic                hit
);
    logic [2:0] part_ok;

    for (genvar g = 0; g < 3; g++) begin : g_part
        if (g == 0) begin : g_ones
            assign part_ok[g] = &window[g*WORD_W +: WORD_W];
        end else begin : g_zeros
            assign part_ok[g] = ~|window[g*WORD_W +: WORD_W];
        end
    end

    assign hit = &part_ok;
endmodule

// File: rtl/sdi_rx_framer.sv
// Word assembly, boundary tracking and lock state machine.
module sdi_rx_framer
    import sdi_rx_pkg::*;
#(
    parameter int WORD_W     = 10,
    parameter int MISS_WORDS = 1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_bit,
    output logic [WORD_W-1:0] word,
    output logic              word_en,
    output logic              locked,
    output logic              sync_hit,
    output logic              aligned
);
    localparam int WIN_W  = 3 * WORD_W;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int MISS_W = $clog2(MISS_WORDS + 1);

    logic [WIN_W-1:0]  win;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  cur_idx;
    logic [MISS_W-1:0] miss_cnt;
    logic              emit;
    logic              expire;
    lock_state_t       state;
    lock_state_t       nxt;

    sdi_rx_sync_det #(.WORD_W(WORD_W)) u_det (
        .window (win),
        .hit    (sync_hit)
    );

    // A preamble forces the bit arriving now to be bit 0 of a word.
    assign cur_idx = sync_hit ? '0 : bit_idx;
    assign aligned = sync_hit && (bit_idx == '0);
    assign emit    = (cur_idx == IDX_W'(WORD_W - 1));
    assign expire  = emit && !sync_hit && (miss_cnt == MISS_W'(MISS_WORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win      <= '0;
            bit_idx  <= '0;
            miss_cnt <= '0;
            word     <= '0;
            word_en  <= 1'b0;
        end else begin
            win     <= {data_bit, win[WIN_W-1:1]};
            bit_idx <= emit ? '0 : cur_idx + IDX_W'(1);
            word_en <= emit;
            if (emit) begin
                word <= {data_bit, win[WIN_W-1:WIN_W-WORD_W+1]};
            end
            if (sync_hit) begin
                miss_cnt <= '0;
            end else if (emit && (miss_cnt != MISS_W'(MISS_WORDS - 1))) begin
                miss_cnt <= miss_cnt + MISS_W'(1);
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEEK;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SEEK: begin
                if (sync_hit) nxt = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (aligned)       nxt = ST_LOCKED;
                else if (sync_hit) nxt = ST_VERIFY;
                else if (expire)   nxt = ST_SEEK;
            end
            ST_LOCKED: begin
                if (sync_hit && !aligned) nxt = ST_VERIFY;
                else if (expire)          nxt = ST_SEEK;
            end
            default: nxt = ST_SEEK;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else begin
            locked <= (nxt == ST_LOCKED);
        end
    end
endmodule

// File: rtl/sdi_rx_deframer.sv
module sdi_rx_deframer #(
    parameter int WORD_W     = 10,
    parameter int TAP_A      = 4,
    parameter int TAP_B      = 9,
    parameter int MISS_WORDS = 1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              bypass,
    output logic [WORD_W-1:0] word_out,
    output logic              word_en,
    output logic              locked
);
    logic data_bit;
    logic sync_hit;
    logic aligned;

    sdi_rx_bitdec #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_bit (ser_in),
        .bypass   (bypass),
        .data_bit (data_bit)
    );

    sdi_rx_framer #(.WORD_W(WORD_W), .MISS_WORDS(MISS_WORDS)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_bit (data_bit),
        .word     (word_out),
        .word_en  (word_en),
        .locked   (locked),
        .sync_hit (sync_hit),
        .aligned  (aligned)
    );
endmodule

// File: rtl/sdi_rx_deframer_chk.sv
module sdi_rx_deframer_chk #(
    parameter int WORD_W     = 10,
    parameter int MISS_WORDS = 1800
) (
    input logic clk,
    input logic rst_n,
    input logic word_en,
    input logic locked,
    input logic sync_hit,
    input logic aligned
);
    localparam int CNT_W = $clog2(MISS_WORDS + 1);

    logic [4:0]       gap;
    logic             seen;
    logic [CNT_W-1:0] since;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap   <= '0;
            seen  <= 1'b0;
            since <= '0;
        end else begin
            if (word_en) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap != 5'd31) begin
                gap <= gap + 5'd1;
            end
            if (sync_hit) begin
                since <= '0;
            end else if (word_en && (since != CNT_W'(MISS_WORDS))) begin
                since <= since + CNT_W'(1);
            end
        end
    end

    a_r5_word_period: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && word_en && seen) |-> (gap == 5'(WORD_W - 1)));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_en |=> !word_en);

    a_r7_lock_on_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(sync_hit && aligned));

    a_r8_slip_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_hit && !aligned) |=> !locked);

    a_r9_miss_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (since == CNT_W'(MISS_WORDS)) |-> !locked);

    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!locked && !word_en));
endmodule

bind sdi_rx_deframer sdi_rx_deframer_chk #(
    .WORD_W     (WORD_W),
    .MISS_WORDS (MISS_WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_en  (word_en),
    .locked   (locked),
    .sync_hit (sync_hit),
    .aligned  (aligned)
);

// File: tb/sim_sdi_rx_deframer.sv
`timescale 1ns/1ps
module sim_sdi_rx_deframer;
    localparam int MISS = 24;
    localparam int LOGN = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       bypass = 1'b0;
    logic [9:0] word_out;
    logic       word_en;
    logic       locked;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench line-coder model state
    logic [8:0] yh = '0;
    logic       line = 1'b0;
    logic       raw_mode = 1'b0;

    // monitor state
    logic [9:0] wl [LOGN];
    int         wn = 0;
    logic       chk_period = 1'b0;
    logic       have_prev = 1'b0;
    int         prev_cyc = 0;

    sdi_rx_deframer #(.MISS_WORDS(MISS)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .bypass   (bypass),
        .word_out (word_out),
        .word_en  (word_en),
        .locked   (locked)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [9:0] pay(input int seed, input int i);
        return 10'(8 + ((seed * 131 + i * 37) % 1000));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Word monitor and word-rate check (R5)
    always @(negedge clk) begin
        if (word_en) begin
            if (wn < LOGN) begin
                wl[wn] = word_out;
                wn++;
            end
            if (chk_period && have_prev) check("R5 word spacing", cyc - prev_cyc, 10);
            have_prev = 1'b1;
            prev_cyc  = cyc;
        end
    end

    // Scramble (x^9+x^4+1) and NRZI-encode one bit, unless in raw mode
    task automatic send_bit(input logic x);
        logic y;
        if (raw_mode) begin
            line = x;
        end else begin
            y    = x ^ yh[3] ^ yh[8];
            yh   = {yh[7:0], y};
            line = line ^ y;
        end
        @(negedge clk);
        ser_in = line;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    task automatic send_line(input int seed);
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h000);
        for (int i = 0; i < 12; i++) send_word(pay(seed, i));
    endtask

    task automatic check_payload(input string req, input int seed);
        int found = 0;
        for (int j = 0; j + 14 < wn; j++) begin
            if (found == 0 && wl[j] == 10'h3FF && wl[j+1] == 10'h000 &&
                wl[j+2] == 10'h000 && wl[j+3] == pay(seed, 0)) begin
                found = 1;
                for (int i = 0; i < 12; i++) check(req, wl[j+3+i], pay(seed, i));
            end
        end
        check({req, " payload found"}, found, 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        yh    = '0;
        line  = 1'b0;
        ser_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R10: quiet after reset
        check("R10 locked after reset", locked, 0);
        check("R10 word_en after reset", word_en, 0);

        for (int i = 0; i < 4; i++) send_word(pay(90, i));
        send_line(1);
        check("R7 unlocked after one preamble", locked, 0);
        send_line(2);
        check("R7 locked after second preamble", locked, 1);
        chk_period = 1'b1;
        send_line(3);
        chk_period = 1'b0;
        check_payload("R1 R2 R4 R6 decoded words", 2);

        // R8: three-bit slip shifts the boundary
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_line(4);
        check("R8 unlocked after slipped preamble", locked, 0);
        send_line(5);
        check("R8 relocked at new offset", locked, 1);
        send_line(6);
        check_payload("R8 words after realign", 5);

        // R9: loss of preamble
        for (int i = 0; i < 8; i++) send_word(pay(7, i));
        check("R9 still locked below limit", locked, 1);
        for (int i = 8; i < 16; i++) send_word(pay(7, i));
        check("R9 unlocked past limit", locked, 0);

        // R3: bypass, raw bits LSB first
        bypass   = 1'b1;
        raw_mode = 1'b1;
        do_reset();
        check("R10 locked after second reset", locked, 0);
        send_line(8);
        send_line(9);
        check("R3 locked in bypass", locked, 1);
        send_line(10);
        check_payload("R3 R4 bypass words", 9);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule